// File: doc/BRIEF.md
# Port Error Logger with First-Error Capture

This block sits beside the host-side port of an accelerator and collects protocol-violation detections. Each detector delivers a one-cycle pulse; the block latches every pulse into a sticky error register and, separately, keeps a first-error register. The first-error register holds only the bit of the error that arrived earliest. Software clears errors by writing ones to the bits it wants cleared. Clearing every error bit also empties the first-error register.

Any new error closes the port. The top bit of the error register then reads as a traffic-blocked flag, and the traffic-enable output drops. While the port is closed, reads of the port-control register return all ones, so software cannot do a read-modify-write on it and writes whole values instead. Writing 0x5 puts the port into reset and writing 0x4 takes it out. After that release, the port reopens only once no MMIO request has been outstanding for a full timeout window.

The block also tracks MMIO requests sent to the accelerator. A request left without a response for the timeout length raises an error of its own and is abandoned.

Top module: `port_err_logger`

## Requirements
- R1: After reset, the error register (address 0) and the first-error register (address 1) read 0, the port-control register (address 2) reads 0x4, `port_rst` is 0 and `traffic_ok` is 1.
- R2: A pulse on `err_det[i]` sets bit i of the error register on the next clock edge, and the bit stays set until software clears it. The bits are: 0 malformed packet, 1 payload above maximum, 2 tag above maximum, 3 MMIO payload overrun, 4 MMIO data short, 5 MMIO timeout, 6 outbound write payload overrun, 7 outbound write data short, 8 unexpected MMIO response.
- R3: While any error bit is set, the first-error register has exactly one bit set. That bit is the lowest-numbered error of the earliest cycle in which errors arrived; errors that arrive later do not change it.
- R4: A write to address 0 clears each error bit 0..8 whose data bit is 1 and leaves the other bits alone. A pulse in the same cycle wins over the clear. Bit 31 cannot be cleared by a write. Writes to address 1 have no effect.
- R5: The first-error register returns to 0 when a write leaves error bits 0..8 all zero. After a partial clear it keeps its bit. If errors arrive in the same cycle as a full clear, the first-error register captures the lowest of them.
- R6: An error arriving while the port is open sets bit 31 of the error register and drops `traffic_ok` on the next edge.
- R7: In the port-control register, bit 0 drives `port_rst` and bit 2 is a stored bit that resets to 1. While bit 31 is set, reads of address 2 return 0xFFFFFFFF.
- R8: An MMIO request that receives no response for TMO_CYC clock edges sets error bit 5 on edge TMO_CYC after the request edge, and every outstanding request is abandoned. A request that is answered in time raises no error.
- R9: Bit 31 stays set while the port is waiting for reset and while reset is held, whatever happens to the error bits. After reset is released it clears on edge TMO_CYC+1 after the release edge, provided no request is outstanding during that time.
- R10: A request outstanding during the drain window restarts the window, so the port stays closed longer.
- R11: `traffic_ok` is 0 whenever `port_rst` is 1, even when no error has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_det | input | 9 | One-cycle error detect pulses, one per source |
| mmio_req | input | 1 | An MMIO request is issued to the accelerator this cycle |
| mmio_rsp | input | 1 | An MMIO response returns this cycle |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address (0 error, 1 first error, 2 port control) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| port_rst | output | 1 | Port reset, bit 0 of port control |
| traffic_ok | output | 1 | Traffic to the accelerator is allowed |

## Verification
The bench builds the block with TMO_CYC set to 32 and OUTS_W set to 3. With a short timeout, the exact edge on which a timeout fires and the exact edge on which the drain completes can both be checked directly, and the bench can run several complete block, reset and drain cycles. A three-bit outstanding counter keeps saturation within a few requests. The random phase shows many overlaps of pulse batches with clear writes, which exercises the first-error choice and the same-cycle clear-versus-set ordering.

// File: rtl/pel_pkg.sv
package pel_pkg;
  localparam int ERR_N  = 9;
  localparam int DW     = 32;
  localparam int AW     = 2;
  localparam int SRC_TMO = 5;

  localparam logic [AW-1:0] A_ERR   = 2'd0;
  localparam logic [AW-1:0] A_FIRST = 2'd1;
  localparam logic [AW-1:0] A_CTL   = 2'd2;

  typedef enum logic [1:0] {
    ST_OPEN,
    ST_WAIT_RST,
    ST_IN_RST,
    ST_DRAIN
  } gate_st_e;

  // lowest set bit of a pulse batch
  function automatic logic [ERR_N-1:0] pick_lowest(input logic [ERR_N-1:0] v);
    logic [ERR_N-1:0] r;
    r = '0;
    for (int i = ERR_N - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [ERR_N-1:0] w1c_apply(input logic [ERR_N-1:0] cur,
                                                 input logic [ERR_N-1:0] mask);
    return cur & ~mask;
  endfunction
endpackage

// File: rtl/pel_mmio_watch.sv
module pel_mmio_watch #(
  parameter int TMO_CYC = 512,
  parameter int OUTS_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mmio_req,
  input  logic mmio_rsp,
  output logic tmo_fire,
  output logic quiet
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);

  logic [OUTS_W-1:0] outs_q;
  logic [TMO_W-1:0]  wait_q;
  logic              waiting;
  logic              rsp_ok;

  assign waiting  = (outs_q != '0);
  assign rsp_ok   = mmio_rsp && waiting;
  assign tmo_fire = waiting && !mmio_rsp && (wait_q == TMO_LAST);
  assign quiet    = !waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outs_q <= '0;
    end else if (tmo_fire) begin
      outs_q <= mmio_req ? OUTS_W'(1) : '0;
    end else if (mmio_req && !rsp_ok && (outs_q != '1)) begin
      outs_q <= outs_q + 1'b1;
    end else if (!mmio_req && rsp_ok) begin
      outs_q <= outs_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (!waiting || mmio_rsp || tmo_fire) begin
      wait_q <= '0;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  // R8
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (outs_q <= OUTS_W'(1)));
  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q <= TMO_LAST);
endmodule

// File: rtl/pel_err_regs.sv
module pel_err_regs
  import pel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] det,
  input  logic [ERR_N-1:0] clr_mask,
  output logic [ERR_N-1:0] err_q,
  output logic [ERR_N-1:0] first_q,
  output logic             new_err
);
  logic [ERR_N-1:0] kept;
  logic [ERR_N-1:0] first_base;
  logic [ERR_N-1:0] first_next;

  assign new_err    = (det != '0);
  assign kept       = w1c_apply(err_q, clr_mask);
  assign first_base = (kept == '0) ? '0 : first_q;
  assign first_next = ((first_base == '0) && new_err) ? pick_lowest(det) : first_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      first_q <= '0;
    end else begin
      err_q   <= kept | det;
      first_q <= first_next;
    end
  end

  for (genvar gi = 0; gi < ERR_N; gi++) begin : g_latch
    // R2
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det[gi] |=> err_q[gi]);
  end

  // R3
  first_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != '0) |-> ($countones(first_q) == 1));
  // R5
  first_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == '0) |-> (first_q == '0));
  // R3
  first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((first_q != '0) && (clr_mask == '0)) |=> $stable(first_q));
endmodule

// File: rtl/pel_block_ctl.sv
module pel_block_ctl
  import pel_pkg::*;
#(
  parameter int TMO_CYC = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       new_err,
  input  logic       quiet,
  input  logic       ctl_we,
  input  logic       ctl_rst_bit,
  input  logic       ctl_keep_bit,
  output logic       blocking,
  output logic       port_rst,
  output logic [2:0] ctl_q
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [TMO_W-1:0] QUIET_LAST = TMO_W'(TMO_CYC - 1);

  gate_st_e       st_q;
  logic [TMO_W-1:0] qcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 3'b100;
    end else if (ctl_we) begin
      ctl_q <= {ctl_keep_bit, 1'b0, ctl_rst_bit};
    end
  end

  assign port_rst = ctl_q[0];
  assign blocking = (st_q != ST_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OPEN;
      qcnt_q <= '0;
    end else begin
      case (st_q)
        ST_OPEN:     if (new_err) st_q <= ST_WAIT_RST;
        ST_WAIT_RST: if (port_rst) st_q <= ST_IN_RST;
        ST_IN_RST: begin
          if (!port_rst) begin
            st_q   <= ST_DRAIN;
            qcnt_q <= '0;
          end
        end
        ST_DRAIN: begin
          if (port_rst) begin
            st_q <= ST_IN_RST;
          end else if (!quiet) begin
            qcnt_q <= '0;
          end else if (qcnt_q == QUIET_LAST) begin
            st_q   <= ST_OPEN;
            qcnt_q <= '0;
          end else begin
            qcnt_q <= qcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_OPEN;
      endcase
    end
  end

  // R6
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocking && new_err) |=> blocking);
  // R9
  hold_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocking && port_rst) |=> blocking);
  // R10
  busy_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocking && !quiet) |=> blocking);
endmodule

// File: rtl/port_err_logger.sv
module port_err_logger
  import pel_pkg::*;
#(
  parameter int TMO_CYC = 512,
  parameter int OUTS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] err_det,
  input  logic             mmio_req,
  input  logic             mmio_rsp,
  input  logic             csr_wr,
  input  logic [AW-1:0]    csr_addr,
  input  logic [DW-1:0]    csr_wdata,
  output logic [DW-1:0]    csr_rdata,
  output logic             port_rst,
  output logic             traffic_ok
);
  localparam int PAD_ERR   = DW - 1 - ERR_N;
  localparam int PAD_FIRST = DW - ERR_N;

  logic             tmo_fire;
  logic             quiet;
  logic [ERR_N-1:0] det_all;
  logic [ERR_N-1:0] clr_mask;
  logic [ERR_N-1:0] err_q;
  logic [ERR_N-1:0] first_q;
  logic             new_err;
  logic             blocking;
  logic [2:0]       ctl_q;
  logic             ctl_we;
  logic             unused_wbits;

  assign unused_wbits = ^csr_wdata[DW-1:ERR_N];

  pel_mmio_watch #(.TMO_CYC(TMO_CYC), .OUTS_W(OUTS_W)) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .mmio_req (mmio_req),
    .mmio_rsp (mmio_rsp),
    .tmo_fire (tmo_fire),
    .quiet    (quiet)
  );

  always_comb begin
    det_all          = err_det;
    det_all[SRC_TMO] = err_det[SRC_TMO] | tmo_fire;
  end

  assign clr_mask = (csr_wr && (csr_addr == A_ERR)) ? csr_wdata[ERR_N-1:0] : '0;
  assign ctl_we   = csr_wr && (csr_addr == A_CTL);

  pel_err_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .det      (det_all),
    .clr_mask (clr_mask),
    .err_q    (err_q),
    .first_q  (first_q),
    .new_err  (new_err)
  );

  pel_block_ctl #(.TMO_CYC(TMO_CYC)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .new_err      (new_err),
    .quiet        (quiet),
    .ctl_we       (ctl_we),
    .ctl_rst_bit  (csr_wdata[0]),
    .ctl_keep_bit (csr_wdata[2]),
    .blocking     (blocking),
    .port_rst     (port_rst),
    .ctl_q        (ctl_q)
  );

  always_comb begin
    case (csr_addr)
      A_ERR:   csr_rdata = {blocking, {PAD_ERR{1'b0}}, err_q};
      A_FIRST: csr_rdata = {{PAD_FIRST{1'b0}}, first_q};
      A_CTL:   csr_rdata = blocking ? '1 : {{(DW-3){1'b0}}, ctl_q};
      default: csr_rdata = '0;
    endcase
  end

  assign traffic_ok = !blocking && !port_rst;

  // R7
  ctl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocking && (csr_addr == A_CTL)) |-> (csr_rdata == '1));
  // R11
  gate_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |-> !traffic_ok);
  // R8
  tmo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> csr_rdata[SRC_TMO] || (csr_addr != A_ERR));
endmodule

// File: tb/sim_port_err_logger.sv
`timescale 1ns/100ps
module sim_port_err_logger;
  localparam int TMO = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  err_det = '0;
  logic        mmio_req = 1'b0;
  logic        mmio_rsp = 1'b0;
  logic        csr_wr = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        port_rst;
  logic        traffic_ok;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  port_err_logger #(.TMO_CYC(TMO), .OUTS_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .err_det(err_det), .mmio_req(mmio_req),
    .mmio_rsp(mmio_rsp), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .port_rst(port_rst),
    .traffic_ok(traffic_ok)
  );

  always #2 clk = ~clk;

  function automatic logic [8:0] low_bit(input logic [8:0] v);
    return v & (~v + 9'd1);
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a;
    #0.2;
    d = csr_rdata;
  endtask

  task automatic cwr(input logic [1:0] a, input logic [31:0] d);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic pulse(input logic [8:0] v);
    err_det = v;
    @(posedge clk); @(negedge clk);
    err_det = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [8:0] m_err, m_first, det, clr;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 err", d, 32'h0);
    rd(1, d); chk("R1 first", d, 32'h0);
    rd(2, d); chk("R1 ctl", d, 32'h4);
    chk("R1 port_rst", {31'b0, port_rst}, 32'h0);
    chk("R1 traffic_ok", {31'b0, traffic_ok}, 32'h1);

    // R2 R3 R6 R7
    pulse(9'h088);
    rd(0, d); chk("R2 latch batch", d, 32'h8000_0088);
    rd(1, d); chk("R3 lowest of batch", d, 32'h8);
    chk("R6 traffic off", {31'b0, traffic_ok}, 32'h0);
    rd(2, d); chk("R7 ctl all ones while blocked", d, 32'hFFFF_FFFF);
    pulse(9'h002);
    rd(0, d); chk("R2 later latch", d, 32'h8000_008A);
    rd(1, d); chk("R3 later error ignored", d, 32'h8);
    // R4 write to first-error address ignored
    cwr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R4 first write ignored", d, 32'h8);
    cwr(0, 32'h0000_0080);
    rd(0, d); chk("R4 partial w1c", d, 32'h8000_000A);
    cwr(0, 32'h8000_0008);
    rd(0, d); chk("R4 bit31 kept", d, 32'h8000_0002);
    rd(1, d); chk("R5 partial clear keeps first", d, 32'h8);
    // R5 clear all with a new pulse in the same cycle
    csr_wr = 1'b1; csr_addr = 0; csr_wdata = 32'h2; err_det = 9'h011;
    @(posedge clk); @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0; err_det = '0;
    rd(0, d); chk("R4 set wins clear", d, 32'h8000_0011);
    rd(1, d); chk("R5 recapture", d, 32'h1);
    cwr(0, 32'h0000_01FF);
    rd(0, d); chk("R9 block survives clear", d, 32'h8000_0000);
    rd(1, d); chk("R5 first cleared", d, 32'h0);

    // R9 R10 drain with a request inside the window
    cwr(2, 32'h5);
    chk("R7 port_rst set", {31'b0, port_rst}, 32'h1);
    ticks(3 * TMO);
    rd(0, d); chk("R9 held in reset", d, 32'h8000_0000);
    cwr(2, 32'h4);
    chk("R7 port_rst released", {31'b0, port_rst}, 32'h0);
    ticks(TMO / 2);
    mmio_req = 1'b1; @(posedge clk); @(negedge clk); mmio_req = 1'b0;
    ticks(3);
    mmio_rsp = 1'b1; @(posedge clk); @(negedge clk); mmio_rsp = 1'b0;
    ticks(TMO / 2);
    rd(0, d); chk("R10 window restarted", d[31:0], 32'h8000_0000);
    ticks(TMO + 4);
    rd(0, d); chk("R9 reopened", d, 32'h0);
    rd(2, d); chk("R7 ctl readable", d, 32'h4);
    chk("R9 traffic on", {31'b0, traffic_ok}, 32'h1);

    // R11 reset without error
    cwr(2, 32'h1);
    chk("R11 traffic off in reset", {31'b0, traffic_ok}, 32'h0);
    rd(2, d); chk("R7 bit2 stored", d, 32'h1);
    cwr(2, 32'h4);
    chk("R11 traffic back", {31'b0, traffic_ok}, 32'h1);

    // R8 answered request
    mmio_req = 1'b1; @(posedge clk); @(negedge clk); mmio_req = 1'b0;
    ticks(8);
    mmio_rsp = 1'b1; @(posedge clk); @(negedge clk); mmio_rsp = 1'b0;
    ticks(2 * TMO);
    rd(0, d); chk("R8 no timeout when answered", d, 32'h0);
    // R8 exact timeout edge
    mmio_req = 1'b1; @(posedge clk); @(negedge clk); mmio_req = 1'b0;
    ticks(TMO - 1);
    rd(0, d); chk("R8 not yet", d, 32'h0);
    ticks(1);
    rd(0, d); chk("R8 timeout bit", d, 32'h8000_0020);
    rd(1, d); chk("R8 timeout first", d, 32'h20);

    // R9 exact drain edge
    cwr(2, 32'h5);
    ticks(3);
    cwr(2, 32'h4);
    ticks(TMO);
    rd(0, d); chk("R9 still draining", d[31:0] & 32'h8000_0000, 32'h8000_0000);
    ticks(1);
    rd(0, d); chk("R9 open on exact edge", d, 32'h0000_0020);

    // random phase for R2 R3 R4 R5
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    m_err = '0; m_first = '0;
    void'($urandom(32'd1234));
    for (int it = 0; it < 400; it++) begin
      det = ($urandom % 3 == 0) ? 9'($urandom) : 9'h0;
      clr = '0;
      csr_wr = 1'b0;
      case ($urandom % 4)
        0: begin csr_wr = 1'b1; csr_addr = 0; csr_wdata = $urandom; clr = csr_wdata[8:0]; end
        1: begin csr_wr = 1'b1; csr_addr = 1; csr_wdata = $urandom; end
        default: csr_addr = 0;
      endcase
      err_det = det;
      @(posedge clk); @(negedge clk);
      csr_wr = 1'b0; err_det = '0;
      m_err = m_err & ~clr;
      if (m_err == 9'h0) m_first = '0;
      if (m_first == 9'h0 && det != 9'h0) m_first = low_bit(det);
      m_err = m_err | det;
      rd(0, d); chk("R2 R4 random err", {23'b0, d[8:0]}, {23'b0, m_err});
      rd(1, d); chk("R3 R5 random first", d, {23'b0, m_first});
    end
    summary();
  end
endmodule